// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one vector instruction one element at a time through a vector register file that has a single, slow port. It accepts a decoded operation and then works through the elements in order. For each element it first reads the mask element. If the mask bit is set, it then reads each source operand, one request at a time, passes the operands to a scalar integer lane, and writes the result back. A masked-off element makes no operand reads and no write, and the destination keeps its old value. The operation stops at the active vector length, which is clamped to the register depth.

There are two operation kinds. A two-source add names its mask register explicitly. A three-source multiply-add has no mask field and always uses mask register 0. The 3-bit rounding-mode field chooses between integer and floating-point execution. The lane is an integer stub, so a floating-point encoding completes at once without touching the register file. The register file sits outside the block and is reached through a read-request / read-valid / write port.

Top module: `vec_elem_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. A `start` pulse while `busy` is high is ignored and causes no writes.
- R2: For a two-source add (`op_madd`=0), element i of `vd` becomes `vs1[i] + vs2[i]`, truncated to DW bits, when bit 0 of element i of mask register `vm` is 1.
- R3: An element whose mask bit (bit 0 of that mask element) is 0 gets no write, and its destination value stays unchanged.
- R4: Only elements with an index below min(`vlen`, NELEM) are written. A `vlen` above NELEM is clamped to NELEM.
- R5: For a multiply-add (`op_madd`=1), element i of `vd` becomes `vs1[i]*vs2[i] + vs3[i]`, truncated to DW bits. The mask is always taken from register 0, whatever the `vm` input holds.
- R6: Rounding-mode codes 6 and 7 select integer execution. Codes 0 to 5 are floating-point encodings, which this lane does not execute: `done` rises one cycle after `start`, and nothing is written.
- R7: With an effective length of zero, `done` rises one cycle after `start`, and there are no reads and no writes.
- R8: `done` is a one-cycle pulse. When the last element is written, `done` comes one cycle after the write cycle. `busy` falls in the same cycle that `done` rises.
- R9: The port carries one access at a time. A read request and a write are never asserted together. A new read request is never issued while an earlier read is still outstanding.
- R10: The port address of element e in register r is r*NELEM + e. Within each element, the reads go in the order mask, vs1, vs2, then vs3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction valid, taken when not busy |
| op_madd | input | 1 | 1 = three-source multiply-add, 0 = two-source add |
| rm | input | 3 | Rounding-mode field; 6 and 7 mean integer |
| vd | input | RW | Destination register |
| vs1 | input | RW | First source register |
| vs2 | input | RW | Second source register |
| vs3 | input | RW | Third source register (multiply-add only) |
| vm | input | RW | Mask register (two-source only) |
| vlen | input | LW | Requested vector length |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| rf_rd_en | output | 1 | Read request, one cycle |
| rf_we | output | 1 | Write strobe |
| rf_addr | output | AW | Element slot address |
| rf_wdata | output | DW | Write data |
| rf_rd_valid | input | 1 | Read data valid |
| rf_rdata | input | DW | Read data |

## Verification
Assertions check on every cycle that the port never carries a read and a write together, and that a read request is never followed directly by another one. They also check that every write lands at an element below the clamped length, that `done` is a single pulse that never coincides with `busy`, and that an accepted instruction's fields hold steady while `busy` is high. Some behaviour only the bench scenarios can show: the arithmetic results, the preservation of masked-off elements, the implicit use of mask register 0 by multiply-add, the clamping of an oversized length, the handling of floating-point encodings and of a zero length, and the cycle in which `done` rises after the last write. These are all checked against a snapshot of a register-file model held in the bench.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WDONE = 2'd2
  } seq_state_e;

  localparam logic [2:0] RM_INT_A = 3'd6;
  localparam logic [2:0] RM_INT_B = 3'd7;
endpackage

// File: rtl/vseq_decode.sv
module vseq_decode #(
  parameter int NELEM = 64,
  parameter int RW    = 6,
  parameter int LW    = 7
) (
  input  logic          op_madd,
  input  logic [2:0]    rm,
  input  logic [RW-1:0] vm,
  input  logic [LW-1:0] vlen,
  output logic [RW-1:0] mask_reg,
  output logic [LW-1:0] eff_len,
  output logic          is_int,
  output logic [1:0]    last_k
);
  import vseq_pkg::*;

  always_comb begin
    mask_reg = op_madd ? '0 : vm;
    eff_len  = (int'(vlen) > NELEM) ? LW'(NELEM) : vlen;
    is_int   = (rm == RM_INT_A) || (rm == RM_INT_B);
    last_k   = op_madd ? 2'd3 : 2'd2;
  end
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane #(
  parameter int DW = 32
) (
  input  logic          op_madd,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] y
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod = a * b;
    y    = op_madd ? (prod[DW-1:0] + c) : (a + b);
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int NREGS = 64,
  parameter int NELEM = 64,
  parameter int DW    = 32,
  localparam int RW   = $clog2(NREGS),
  localparam int EW   = $clog2(NELEM),
  localparam int LW   = EW + 1,
  localparam int AW   = $clog2(NREGS * NELEM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_madd,
  input  logic [2:0]    rm,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  input  logic [RW-1:0] vs3,
  input  logic [RW-1:0] vm,
  input  logic [LW-1:0] vlen,
  output logic          busy,
  output logic          done,
  output logic          rf_rd_en,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic          rf_rd_valid,
  input  logic [DW-1:0] rf_rdata
);
  import vseq_pkg::*;

  seq_state_e    state_q;
  logic          op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q, vs3_q, mreg_q;
  logic [LW-1:0] len_q;
  logic [1:0]    lastk_q;
  logic [EW-1:0] elem_q;
  logic [1:0]    k_q;
  logic [DW-1:0] a_q, b_q;

  logic [RW-1:0] dec_mreg;
  logic [LW-1:0] dec_len;
  logic          dec_int;
  logic [1:0]    dec_lastk;
  logic [DW-1:0] lane_b, lane_y;
  logic          last_elem;

  vseq_decode #(.NELEM(NELEM), .RW(RW), .LW(LW)) u_dec (
    .op_madd (op_madd),
    .rm      (rm),
    .vm      (vm),
    .vlen    (vlen),
    .mask_reg(dec_mreg),
    .eff_len (dec_len),
    .is_int  (dec_int),
    .last_k  (dec_lastk)
  );

  assign lane_b = (k_q == 2'd2) ? rf_rdata : b_q;

  vseq_lane #(.DW(DW)) u_lane (
    .op_madd(op_q),
    .a      (a_q),
    .b      (lane_b),
    .c      (rf_rdata),
    .y      (lane_y)
  );

  function automatic logic [AW-1:0] slot(input logic [RW-1:0] r, input logic [EW-1:0] e);
    return AW'(r) * AW'(NELEM) + AW'(e);
  endfunction

  function automatic logic [RW-1:0] opnd_reg(input logic [1:0] k);
    case (k)
      2'd0:    return mreg_q;
      2'd1:    return vs1_q;
      2'd2:    return vs2_q;
      default: return vs3_q;
    endcase
  endfunction

  assign last_elem = (LW'(elem_q) == len_q - LW'(1));
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      done     <= 1'b0;
      rf_rd_en <= 1'b0;
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      op_q     <= 1'b0;
      vd_q     <= '0;
      vs1_q    <= '0;
      vs2_q    <= '0;
      vs3_q    <= '0;
      mreg_q   <= '0;
      len_q    <= '0;
      lastk_q  <= 2'd2;
      elem_q   <= '0;
      k_q      <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else begin
      done     <= 1'b0;
      rf_rd_en <= 1'b0;
      rf_we    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_madd;
            vd_q    <= vd;
            vs1_q   <= vs1;
            vs2_q   <= vs2;
            vs3_q   <= vs3;
            mreg_q  <= dec_mreg;
            len_q   <= dec_len;
            lastk_q <= dec_lastk;
            elem_q  <= '0;
            k_q     <= 2'd0;
            if (dec_len == '0 || !dec_int) begin
              done <= 1'b1;
            end else begin
              state_q  <= ST_WAIT;
              rf_rd_en <= 1'b1;
              rf_addr  <= slot(dec_mreg, '0);
            end
          end
        end
        ST_WAIT: begin
          if (rf_rd_valid) begin
            if (k_q == 2'd0 && !rf_rdata[0]) begin
              if (last_elem) begin
                state_q <= ST_IDLE;
                done    <= 1'b1;
              end else begin
                elem_q   <= elem_q + EW'(1);
                rf_rd_en <= 1'b1;
                rf_addr  <= slot(mreg_q, elem_q + EW'(1));
              end
            end else if (k_q == lastk_q) begin
              rf_we    <= 1'b1;
              rf_addr  <= slot(vd_q, elem_q);
              rf_wdata <= lane_y;
              state_q  <= ST_WDONE;
            end else begin
              if (k_q == 2'd1) a_q <= rf_rdata;
              if (k_q == 2'd2) b_q <= rf_rdata;
              k_q      <= k_q + 2'd1;
              rf_rd_en <= 1'b1;
              rf_addr  <= slot(opnd_reg(k_q + 2'd1), elem_q);
            end
          end
        end
        default: begin
          k_q <= 2'd0;
          if (last_elem) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            elem_q   <= elem_q + EW'(1);
            rf_rd_en <= 1'b1;
            rf_addr  <= slot(mreg_q, elem_q + EW'(1));
            state_q  <= ST_WAIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int NELEM = 64,
  parameter int AW    = 12,
  parameter int LW    = 7,
  parameter int RW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          rf_rd_en,
  input logic          rf_we,
  input logic [AW-1:0] rf_addr,
  input logic [LW-1:0] len_q,
  input logic [RW-1:0] vd_q
);
  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rf_rd_en && rf_we));

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (rst) rf_rd_en |=> !rf_rd_en);

  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (int'(rf_addr) % NELEM) < int'(len_q));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  // R1
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(vd_q) && $stable(len_q)));
endmodule

bind vec_elem_seq vseq_chk #(.NELEM(NELEM), .AW(AW), .LW(LW), .RW(RW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .rf_rd_en(rf_rd_en),
  .rf_we   (rf_we),
  .rf_addr (rf_addr),
  .len_q   (len_q),
  .vd_q    (vd_q)
);

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 8;
  localparam int NELEM = 16;
  localparam int DW    = 16;
  localparam int RW    = $clog2(NREGS);
  localparam int LW    = $clog2(NELEM) + 1;
  localparam int AW    = $clog2(NREGS * NELEM);
  localparam int SLOTS = NREGS * NELEM;
  localparam int LAT   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_madd = 1'b0;
  logic [2:0] rm = 3'd6;
  logic [RW-1:0] vd = '0, vs1 = '0, vs2 = '0, vs3 = '0, vm = '0;
  logic [LW-1:0] vlen = '0;
  logic busy, done, rf_rd_en, rf_we, rf_rd_valid;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata, rf_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_seq #(.NREGS(NREGS), .NELEM(NELEM), .DW(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .op_madd(op_madd), .rm(rm),
    .vd(vd), .vs1(vs1), .vs2(vs2), .vs3(vs3), .vm(vm), .vlen(vlen),
    .busy(busy), .done(done), .rf_rd_en(rf_rd_en), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rd_valid(rf_rd_valid), .rf_rdata(rf_rdata)
  );

  // register file model: single port, LAT-cycle reads
  logic [DW-1:0] mem [SLOTS];
  logic [LAT-1:0] vpipe;
  logic [AW-1:0]  apipe [LAT];
  int cyc, lastwr, nwr, conflicts;

  assign rf_rd_valid = vpipe[LAT-1];
  assign rf_rdata    = mem[apipe[LAT-1]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        logic [DW-1:0] v;
        v = DW'(i * 37 + 11) ^ DW'(i >> 2);
        if (i / NELEM == 5) v[0] = ((i % NELEM) % 3 != 1);
        if (i / NELEM == 0) v[0] = ((i % NELEM) % 4 != 2);
        mem[i] = v;
      end
      vpipe <= '0;
      for (int j = 0; j < LAT; j++) apipe[j] <= '0;
      cyc <= 0; lastwr <= -10; nwr <= 0; conflicts <= 0;
    end else begin
      cyc <= cyc + 1;
      vpipe <= {vpipe[LAT-2:0], rf_rd_en};
      apipe[0] <= rf_addr;
      for (int j = 1; j < LAT; j++) apipe[j] <= apipe[j-1];
      if (rf_we) begin
        mem[rf_addr] <= rf_wdata;
        lastwr <= cyc;
        nwr <= nwr + 1;
      end
      if ((rf_rd_en && rf_we) || (rf_rd_en && vpipe != '0)) conflicts <= conflicts + 1;
    end
  end

  int checks = 0, fails = 0;
  bit timed_out = 1'b0;
  logic [DW-1:0] expm [SLOTS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one instruction and checks results; intrude adds a start pulse while busy
  task automatic run_op(input string req, input bit madd, input logic [2:0] rmode,
                        input int d, input int s1, input int s2, input int s3,
                        input int m, input int len, input bit intrude);
    int n, mreg, w0, ewr, t, bad, badi, last_on;
    bit executes;
    n = (len > NELEM) ? NELEM : len;
    mreg = madd ? 0 : m;
    executes = (rmode == 3'd6 || rmode == 3'd7);
    for (int i = 0; i < SLOTS; i++) expm[i] = mem[i];
    ewr = 0; last_on = 0;
    if (executes) begin
      for (int e = 0; e < n; e++) begin
        if (mem[mreg*NELEM+e][0]) begin
          logic [DW-1:0] a, b, c;
          a = mem[s1*NELEM+e]; b = mem[s2*NELEM+e]; c = mem[s3*NELEM+e];
          expm[d*NELEM+e] = madd ? DW'(a*b) + c : a + b;
          ewr++;
          if (e == n-1) last_on = 1;
        end
      end
    end
    w0 = nwr;
    @(negedge clk);
    op_madd = madd; rm = rmode; vd = RW'(d); vs1 = RW'(s1); vs2 = RW'(s2);
    vs3 = RW'(s3); vm = RW'(m); vlen = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!executes || n == 0) begin
      chk(done == 1'b1 && busy == 1'b0, req, int'(done), 1);
    end else begin
      t = 0;
      while (!done && t < 5000) begin
        if (intrude && t == 8) begin
          vd = RW'(d + 1); vlen = LW'(NELEM); start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end else begin
          @(negedge clk);
        end
        t++;
      end
      chk(done == 1'b1, req, int'(done), 1);
      if (last_on) chk(lastwr == cyc - 1, {req, " done timing"}, lastwr, cyc - 1);
    end
    @(negedge clk);
    chk(done == 1'b0, {req, " done one cycle"}, int'(done), 0);
    chk(nwr - w0 == ewr, {req, " write count"}, nwr - w0, ewr);
    bad = 0; badi = -1;
    for (int i = 0; i < SLOTS; i++) if (mem[i] !== expm[i]) begin bad++; if (badi < 0) badi = i; end
    if (badi < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " data"}, int'(mem[badi]), int'(expm[badi]));
  endtask

  task automatic test_reset();
    chk(busy == 1'b0 && done == 1'b0, "R8 reset idle", int'(busy), 0);
    chk(rf_rd_en == 1'b0 && rf_we == 1'b0, "R9 reset port quiet", int'(rf_we), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_op("R2 R3 R10 add mask reg5", 1'b0, 3'd6, 2, 1, 3, 4, 5, 16, 1'b0);
    run_op("R4 R6 short length int code 7", 1'b0, 3'd7, 6, 3, 4, 1, 5, 7, 1'b0);
    run_op("R4 clamp length 20", 1'b0, 3'd6, 7, 1, 2, 3, 5, 20, 1'b0);
    run_op("R5 madd uses mask reg0", 1'b1, 3'd6, 4, 1, 2, 3, 5, 16, 1'b0);
    run_op("R6 float code 2 not executed", 1'b0, 3'd2, 6, 1, 2, 3, 5, 16, 1'b0);
    run_op("R7 zero length", 1'b0, 3'd6, 6, 1, 2, 3, 5, 0, 1'b0);
    run_op("R1 start while busy ignored", 1'b0, 3'd6, 2, 3, 4, 1, 0, 16, 1'b1);
    chk(conflicts == 0, "R9 single access on port", conflicts, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1'b1;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule